// File: doc/BRIEF.md
# Interrupt Request Priority Resolver

This block samples eight interrupt request lines into a request register and decides, every cycle, whether one of them should be presented to the processor. A line may be captured on its rising transition (edge mode) or tracked directly (level mode); the choice is made per line through a small trigger-mode register whose writable bits are fixed at build time. Among the requests that are not masked, the block picks the one with the best priority in a rotating order. It raises its pending output only when that request outranks everything currently marked in service.

The surrounding controller owns the in-service register and feeds it in. When that controller accepts the presented interrupt, it pulses the acknowledge input. The resolver then returns a one-hot vector naming the line whose in-service bit must be set, and drops the captured request of that line if the line is edge-triggered. A fully-nested option lets a master unit disregard the in-service bit of its cascade input, so a slave can still interrupt while an earlier slave interrupt is in service.

Top module: `irq_prio_resolver`

## Requirements
- R1: After reset, `pending` is 0, `line` is 0, `req_reg` is all zeros, `trig_mode` is all zeros (every line edge-triggered) and `isr_set` is all zeros.
- R2: For an edge-triggered line (trig_mode bit 0), the request bit is set one cycle after the input is seen high when it was low on the previous sample. An input that stays high does not set the bit again after it has been cleared.
- R3: For a level-triggered line (trig_mode bit 1), the request bit equals the input level of the previous cycle, set when high and cleared when low.
- R4: A write with `trig_wr` high loads `trig_mode` with `trig_wdata` ANDed with parameter `TRIG_WE_MASK` (default 8'hF8), so bits 0 to 2 always read as zero by default.
- R5: Only requests whose `irq_mask` bit is 0 can win. A masked request never drives `pending`.
- R6: The search starts at line `rot_base` and walks upward modulo 8. The first candidate found wins, and `line` reports the index of that winner.
- R7: `pending` is 1 only when the winner's rank (its distance from `rot_base` in that walk) is strictly smaller than the rank of the best in-service bit in the same walk. Equal rank gives no pending, and an empty in-service set never blocks.
- R8: With `nest_en` high on a master unit (parameter `IS_MASTER`), the in-service bit of line `CASCADE_LINE` (default 2) is ignored when the in-service rank is found.
- R9: `pending` and `line` are registered and reflect the request, mask, in-service, rotation and nesting inputs one cycle after they change. `line` reads 0 whenever `pending` is 0.
- R10: While `ack` is high and `pending` is 1, `isr_set` is the one-hot code of `line`; otherwise it is zero. On such an acknowledge, the accepted line's request bit is cleared at the next edge if the line is edge-triggered and left to follow its input if it is level-triggered.
- R11: If an edge-triggered line is acknowledged in the same cycle as it shows a fresh rising transition, the new transition wins and the request bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_lvl | input | 8 | Raw request levels, one per line |
| irq_mask | input | 8 | 1 blocks the line from winning |
| in_service | input | 8 | In-service register held by the controller |
| trig_wr | input | 1 | Write strobe for the trigger-mode register |
| trig_wdata | input | 8 | Trigger-mode write data, 1 = level, 0 = edge |
| rot_base | input | 3 | Line at which the priority walk starts |
| nest_en | input | 1 | Fully-nested rule enable |
| ack | input | 1 | Controller accepts the presented interrupt |
| pending | output | 1 | An unmasked request outranks all in-service lines |
| line | output | 3 | Index of the winning line |
| isr_set | output | 8 | One-hot in-service bit to set on acknowledge |
| req_reg | output | 8 | Captured request register |
| trig_mode | output | 8 | Trigger-mode register contents |

## Verification
Acknowledge and edge capture can both act on the same request bit in one cycle. The acknowledge tries to clear it, and a new rising transition on that line tries to set it. The bench provokes this by letting a captured edge line go low while it is still presented, then raising it again in the very cycle `ack` is pulsed. The collision is judged correct when the request bit is still set afterwards. A companion case, with the line held high through the acknowledge and no new transition, must show the bit cleared.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    // Capture style selected per line by the trigger-mode register.
    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_kind_e;

endpackage

// File: rtl/irq_prio_scan.sv
// Rotating priority search: returns the walk distance from base to the
// first set bit, or N_LINES when the vector is empty.
module irq_prio_scan #(
    parameter int N_LINES = 8,
    localparam int IDXW   = $clog2(N_LINES),
    localparam int PW     = IDXW + 1
) (
    input  logic [N_LINES-1:0] vec,
    input  logic [IDXW-1:0]    base,
    output logic [PW-1:0]      rank
);

    always_comb begin
        rank = PW'(N_LINES);
        // Walk backwards so the smallest distance is written last.
        for (int c = N_LINES - 1; c >= 0; c--) begin
            logic [IDXW-1:0] idx;
            idx = IDXW'((c + int'(base)) % N_LINES);
            if (vec[idx]) begin
                rank = PW'(c);
            end
        end
    end

endmodule

// File: rtl/irq_req_capture.sv
// Per-line request capture with edge or level behaviour.
module irq_req_capture
    import irq_prio_pkg::*;
#(
    parameter int N_LINES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] lvl,
    input  logic [N_LINES-1:0] mode,
    input  logic [N_LINES-1:0] clr,
    output logic [N_LINES-1:0] req
);

    logic [N_LINES-1:0] prev_lvl;

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_lvl[g] <= 1'b0;
                req[g]      <= 1'b0;
            end else begin
                prev_lvl[g] <= lvl[g];
                if (trig_kind_e'(mode[g]) == TRIG_LEVEL) begin
                    req[g] <= lvl[g];
                end else if (lvl[g] && !prev_lvl[g]) begin
                    // A fresh rising transition beats a same-cycle clear.
                    req[g] <= 1'b1;
                end else if (clr[g]) begin
                    req[g] <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver #(
    parameter int                 N_LINES      = 8,
    parameter int                 CASCADE_LINE = 2,
    parameter bit                 IS_MASTER    = 1'b1,
    parameter logic [N_LINES-1:0] TRIG_WE_MASK = 8'hF8,
    localparam int                IDXW         = $clog2(N_LINES),
    localparam int                PW           = IDXW + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] req_lvl,
    input  logic [N_LINES-1:0] irq_mask,
    input  logic [N_LINES-1:0] in_service,
    input  logic               trig_wr,
    input  logic [N_LINES-1:0] trig_wdata,
    input  logic [IDXW-1:0]    rot_base,
    input  logic               nest_en,
    input  logic               ack,
    output logic               pending,
    output logic [IDXW-1:0]    line,
    output logic [N_LINES-1:0] isr_set,
    output logic [N_LINES-1:0] req_reg,
    output logic [N_LINES-1:0] trig_mode
);

    localparam logic [N_LINES-1:0] ONE_HOT0 = N_LINES'(1);
    localparam logic [N_LINES-1:0] CASC_BIT = ONE_HOT0 << CASCADE_LINE;

    logic [N_LINES-1:0] cand_vec;
    logic [N_LINES-1:0] isr_eff;
    logic [N_LINES-1:0] edge_clr;
    logic [PW-1:0]      cand_rank;
    logic [PW-1:0]      cur_rank;
    logic               win;
    logic [IDXW-1:0]    win_line;
    logic               pending_q;
    logic [IDXW-1:0]    line_q;

    // Trigger-mode register, writable only where the build mask allows.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_mode <= '0;
        end else if (trig_wr) begin
            trig_mode <= trig_wdata & TRIG_WE_MASK;
        end
    end

    // Acknowledge clears only edge-captured requests.
    assign edge_clr = isr_set & ~trig_mode;

    irq_req_capture #(.N_LINES(N_LINES)) u_capture (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (req_lvl),
        .mode  (trig_mode),
        .clr   (edge_clr),
        .req   (req_reg)
    );

    assign cand_vec = req_reg & ~irq_mask;

    // Fully-nested rule on a master hides the cascade line's in-service bit.
    always_comb begin
        isr_eff = in_service;
        if (IS_MASTER && nest_en) begin
            isr_eff = in_service & ~CASC_BIT;
        end
    end

    irq_prio_scan #(.N_LINES(N_LINES)) u_scan_cand (
        .vec  (cand_vec),
        .base (rot_base),
        .rank (cand_rank)
    );

    irq_prio_scan #(.N_LINES(N_LINES)) u_scan_isr (
        .vec  (isr_eff),
        .base (rot_base),
        .rank (cur_rank)
    );

    // An empty candidate set ranks N_LINES and can never be below cur_rank.
    assign win = (cand_rank < cur_rank);

    always_comb begin
        int sum;
        sum      = int'(cand_rank) + int'(rot_base);
        win_line = IDXW'(sum % N_LINES);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
            line_q    <= '0;
        end else begin
            pending_q <= win;
            line_q    <= win ? win_line : '0;
        end
    end

    assign pending = pending_q;
    assign line    = line_q;
    assign isr_set = (ack && pending_q) ? (ONE_HOT0 << line_q) : '0;

endmodule

// File: rtl/irq_prio_resolver_chk.sv
module irq_prio_resolver_chk #(
    parameter int                 N_LINES      = 8,
    parameter logic [N_LINES-1:0] TRIG_WE_MASK = 8'hF8,
    localparam int                IDXW         = $clog2(N_LINES)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_LINES-1:0] req_lvl,
    input logic [N_LINES-1:0] irq_mask,
    input logic               trig_wr,
    input logic [N_LINES-1:0] trig_wdata,
    input logic               pending,
    input logic [IDXW-1:0]    line,
    input logic [N_LINES-1:0] isr_set,
    input logic [N_LINES-1:0] req_reg,
    input logic [N_LINES-1:0] trig_mode
);

    localparam logic [N_LINES-1:0] ONE_HOT0 = N_LINES'(1);

    AST_TRIG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        trig_wr |=> trig_mode == ($past(trig_wdata) & TRIG_WE_MASK)); // R4

    AST_WIN_CANDIDATE: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> ($past(req_reg & ~irq_mask) & (ONE_HOT0 << line)) != '0); // R5

    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(isr_set)); // R10

    for (genvar g = 0; g < N_LINES; g++) begin : g_bit
        AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
            trig_mode[g] |=> req_reg[g] == $past(req_lvl[g])); // R3

        AST_EDGE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
            (!trig_mode[g] && req_lvl[g] && !$past(req_lvl[g])) |=> req_reg[g]); // R11

        AST_ACK_EDGE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (isr_set[g] && !trig_mode[g] && !req_lvl[g]) |=> !req_reg[g]); // R10
    end

endmodule

bind irq_prio_resolver irq_prio_resolver_chk #(
    .N_LINES      (N_LINES),
    .TRIG_WE_MASK (TRIG_WE_MASK)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_lvl    (req_lvl),
    .irq_mask   (irq_mask),
    .trig_wr    (trig_wr),
    .trig_wdata (trig_wdata),
    .pending    (pending),
    .line       (line),
    .isr_set    (isr_set),
    .req_reg    (req_reg),
    .trig_mode  (trig_mode)
);

// File: tb/irq_prio_resolver_test.sv
module irq_prio_resolver_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] req_lvl;
    logic [7:0] irq_mask;
    logic [7:0] in_service;
    logic       trig_wr;
    logic [7:0] trig_wdata;
    logic [2:0] rot_base;
    logic       nest_en;
    logic       ack;
    logic       pending;
    logic [2:0] line;
    logic [7:0] isr_set;
    logic [7:0] req_reg;
    logic [7:0] trig_mode;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    irq_prio_resolver uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_lvl    (req_lvl),
        .irq_mask   (irq_mask),
        .in_service (in_service),
        .trig_wr    (trig_wr),
        .trig_wdata (trig_wdata),
        .rot_base   (rot_base),
        .nest_en    (nest_en),
        .ack        (ack),
        .pending    (pending),
        .line       (line),
        .isr_set    (isr_set),
        .req_reg    (req_reg),
        .trig_mode  (trig_mode)
    );

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_win(string tag, logic p, logic [2:0] l);
        check({tag, " pending"}, {7'd0, pending}, {7'd0, p});
        check({tag, " line"}, {5'd0, line}, {5'd0, l});
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req_lvl = '0; irq_mask = '0; in_service = '0;
        trig_wr = 1'b0; trig_wdata = '0; rot_base = '0; nest_en = 1'b0; ack = 1'b0;
        cyc(2);
        rst_n = 1'b1;
        cyc(1);
    endtask

    task automatic write_trig(logic [7:0] v);
        trig_wr = 1'b1; trig_wdata = v;
        cyc(1);
        trig_wr = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check_win("R1 reset", 1'b0, 3'd0);
        check("R1 req_reg", req_reg, 8'h00);
        check("R1 trig_mode", trig_mode, 8'h00);
        check("R1 isr_set", isr_set, 8'h00);
    endtask

    task automatic t_trig();
        do_reset();
        write_trig(8'hFF);
        check("R4 masked write", trig_mode, 8'hF8);
        write_trig(8'h05);
        check("R4 low bits dropped", trig_mode, 8'h00);
    endtask

    task automatic t_edge();
        do_reset();
        req_lvl = 8'h20;
        cyc(1);
        check("R2 captured", req_reg, 8'h20);
        check("R9 pending lags", {7'd0, pending}, 8'h00);
        cyc(1);
        check_win("R9 edge win", 1'b1, 3'd5);
        check("R10 no ack", isr_set, 8'h00);
        ack = 1'b1;
        #1;
        check("R10 ack onehot", isr_set, 8'h20);
        cyc(1);
        ack = 1'b0;
        in_service = 8'h20;
        check("R10 edge cleared", req_reg, 8'h00);
        cyc(2);
        check("R2 held high no reset", req_reg, 8'h00);
        check_win("R7 nothing left", 1'b0, 3'd0);
    endtask

    task automatic t_level();
        do_reset();
        write_trig(8'h08);
        req_lvl = 8'h08;
        cyc(2);
        check("R3 level set", req_reg, 8'h08);
        check_win("R3 level win", 1'b1, 3'd3);
        ack = 1'b1;
        cyc(1);
        ack = 1'b0;
        check("R10 level kept", req_reg, 8'h08);
        req_lvl = 8'h00;
        cyc(1);
        check("R3 level cleared", req_reg, 8'h00);
    endtask

    task automatic t_mask();
        do_reset();
        irq_mask = 8'h02;
        req_lvl = 8'h42;
        cyc(2);
        check_win("R5 mask low", 1'b1, 3'd6);
        irq_mask = 8'hFF;
        cyc(1);
        check_win("R5 all masked", 1'b0, 3'd0);
        irq_mask = 8'h40;
        cyc(1);
        check_win("R5 mask high", 1'b1, 3'd1);
    endtask

    task automatic t_rotate();
        do_reset();
        req_lvl = 8'h42;
        cyc(2);
        check_win("R6 base0", 1'b1, 3'd1);
        rot_base = 3'd4;
        cyc(1);
        check_win("R6 base4", 1'b1, 3'd6);
        rot_base = 3'd7;
        cyc(1);
        check_win("R6 base7 wrap", 1'b1, 3'd1);
        rot_base = 3'd2;
        cyc(1);
        check_win("R6 base2", 1'b1, 3'd6);
    endtask

    task automatic t_preempt();
        do_reset();
        req_lvl = 8'h42;
        cyc(2);
        in_service = 8'h01;
        cyc(1);
        check_win("R7 higher in service", 1'b0, 3'd0);
        in_service = 8'h10;
        cyc(1);
        check_win("R7 lower in service", 1'b1, 3'd1);
        in_service = 8'h02;
        cyc(1);
        check_win("R7 equal rank", 1'b0, 3'd0);
    endtask

    task automatic t_nested();
        do_reset();
        req_lvl = 8'h20;
        in_service = 8'h04;
        cyc(2);
        check_win("R8 nested off", 1'b0, 3'd0);
        nest_en = 1'b1;
        cyc(1);
        check_win("R8 nested on", 1'b1, 3'd5);
    endtask

    task automatic t_collide();
        do_reset();
        req_lvl = 8'h10;
        cyc(2);
        check_win("R11 setup", 1'b1, 3'd4);
        req_lvl = 8'h00;
        cyc(1);
        check("R2 edge holds", req_reg, 8'h10);
        ack = 1'b1;
        req_lvl = 8'h10;
        #1;
        check("R11 ack onehot", isr_set, 8'h10);
        cyc(1);
        ack = 1'b0;
        check("R11 rise beats clear", req_reg, 8'h10);
    endtask

    initial begin
        t_reset();
        t_trig();
        t_edge();
        t_level();
        t_mask();
        t_rotate();
        t_preempt();
        t_nested();
        t_collide();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule